// File: doc/BRIEF.md
# Display VCOM Polarity Scheduler

This block keeps the common-electrode polarity of a memory-type monochrome display alternating, so that no DC bias builds up across the panel. A mode input chooses where the polarity comes from. With the mode input high, the panel takes its polarity from a dedicated clock pin, and the block drives that pin with a 50% duty square wave. With the mode input low, the panel takes its polarity from a V-bit carried in every command, and the block owns that bit.

In software mode the V-bit inverts each time the command transmitter acknowledges that a command carrying it has gone out. Any command counts, pixel writes included. A keep-alive timer restarts on every acknowledge. If a full toggle period passes with no acknowledge, the block raises a request for a standalone polarity-change command. That request stays up until the transmitter acknowledges a command, so a busy transmitter cannot lose it. The default period is half a second at a 50 MHz clock, which leaves margin against the one-second limit the panel allows.

Top module: `vcom_sched`

## Requirements
- R1: While reset is held, and in the first cycle after it, `vbit`, `ext_clk` and `toggle_req` are all 0.
- R2: In software mode (`ext_mode` = 0), a clock edge with `cmd_sent` = 1 inverts `vbit`, and the new value is visible after that edge. At every other edge `vbit` keeps its value.
- R3: In software mode, `toggle_req` rises after exactly `TOGGLE_CYCLES` clock edges with no `cmd_sent`, counted from reset release, from the last acknowledge, or from the last edge that sampled `ext_mode` = 1.
- R4: Once `toggle_req` is 1 it stays 1 until an edge with `cmd_sent` = 1, and after that edge it is 0.
- R5: Acknowledges spaced fewer than `TOGGLE_CYCLES` edges apart keep `toggle_req` at 0 indefinitely.
- R6: With `ext_mode` = 1, `ext_clk` inverts every `EXT_HALF_CYCLES` edges, giving a 50% duty square wave. The first rise comes after `EXT_HALF_CYCLES` edges that sampled `ext_mode` = 1.
- R7: At the first edge that samples `ext_mode` = 0, `ext_clk` goes to 0 and the divider resets. It stays 0 for as long as software mode holds.
- R8: With `ext_mode` = 1, `toggle_req` is 0 and `vbit` holds its value whatever `cmd_sent` does.
- R9: On a return to software mode, the keep-alive period starts from zero, so `toggle_req` rises `TOGGLE_CYCLES` edges after the last edge that sampled `ext_mode` = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ext_mode | input | 1 | 1: polarity comes from the external clock pin; 0: polarity comes from the V-bit in commands |
| cmd_sent | input | 1 | One-cycle pulse from the transmitter: a command carrying the current V-bit has been sent |
| vbit | output | 1 | V-bit that the transmitter inserts into every command |
| ext_clk | output | 1 | Square-wave polarity clock for the panel pin; 0 in software mode |
| toggle_req | output | 1 | Held request for a standalone polarity-change command |

## Verification
A keep-alive counter that is off by one shows at the ports as `toggle_req` rising one edge early or late. This is visible in the first timeout after reset. A V-bit register that misses or doubles a flip leaves `vbit` at the wrong polarity from the cycle after the acknowledge onward. A divider fault shows as a wrong `ext_clk` edge within one half period of entering external mode. The bench compares all three outputs against a model in every cycle, so each of these faults is caught in the cycle it first appears.

// File: rtl/vcom_pkg.sv
package vcom_pkg;
   typedef enum logic {
      POL_SOFT = 1'b0,
      POL_EXT  = 1'b1
   } pol_src_e;
endpackage

// File: rtl/vcom_keepalive.sv
module vcom_keepalive #(
   parameter int TOGGLE_CYCLES = 25_000_000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic soft_en,
   input  logic ack,
   output logic req
);
   localparam int KA_W = $clog2(TOGGLE_CYCLES);
   localparam logic [KA_W-1:0] KA_LAST = KA_W'(TOGGLE_CYCLES - 1);

   logic [KA_W-1:0] ka_cnt;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ka_cnt <= '0;
         req    <= 1'b0;
      end else if (!soft_en || ack) begin
         ka_cnt <= '0;
         req    <= 1'b0;
      end else if (ka_cnt == KA_LAST) begin
         req    <= 1'b1;
      end else begin
         ka_cnt <= ka_cnt + 1'b1;
      end
   end
endmodule

// File: rtl/vcom_vbit.sv
module vcom_vbit #(
   parameter bit VBIT_INIT = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic soft_en,
   input  logic ack,
   output logic vbit
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         vbit <= VBIT_INIT;
      end else if (soft_en && ack) begin
         vbit <= ~vbit;
      end
   end
endmodule

// File: rtl/vcom_extclk_div.sv
module vcom_extclk_div #(
   parameter int EXT_HALF_CYCLES = 12_500_000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   output logic clk_out
);
   localparam int DIV_W = (EXT_HALF_CYCLES > 1) ? $clog2(EXT_HALF_CYCLES) : 1;
   localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(EXT_HALF_CYCLES - 1);

   logic [DIV_W-1:0] div_cnt;

   always_ff @(posedge clk) begin
      if (!rst_n || !run) begin
         div_cnt <= '0;
         clk_out <= 1'b0;
      end else if (div_cnt == DIV_LAST) begin
         div_cnt <= '0;
         clk_out <= ~clk_out;
      end else begin
         div_cnt <= div_cnt + 1'b1;
      end
   end
endmodule

// File: rtl/vcom_sched.sv
module vcom_sched
   import vcom_pkg::*;
#(
   parameter int CYCLES_PER_SEC  = 50_000_000,
   parameter int TOGGLE_CYCLES   = 25_000_000,
   parameter int EXT_HALF_CYCLES = 12_500_000,
   parameter bit EXT_CLK_EN      = 1'b1,
   parameter bit VBIT_INIT       = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic ext_mode,
   input  logic cmd_sent,
   output logic vbit,
   output logic ext_clk,
   output logic toggle_req
);
   initial begin : p_param_chk
      assert (TOGGLE_CYCLES >= 2)
         else $fatal(1, "TOGGLE_CYCLES must be at least 2");
      assert (TOGGLE_CYCLES <= CYCLES_PER_SEC)
         else $fatal(1, "TOGGLE_CYCLES exceeds one second");
      assert (EXT_HALF_CYCLES >= 1)
         else $fatal(1, "EXT_HALF_CYCLES must be at least 1");
   end

   pol_src_e pol_src;
   logic     soft_en;

   assign pol_src = pol_src_e'(ext_mode);
   assign soft_en = (pol_src == POL_SOFT);

   vcom_keepalive #(.TOGGLE_CYCLES(TOGGLE_CYCLES)) u_keepalive (
      .clk     (clk),
      .rst_n   (rst_n),
      .soft_en (soft_en),
      .ack     (cmd_sent),
      .req     (toggle_req)
   );

   vcom_vbit #(.VBIT_INIT(VBIT_INIT)) u_vbit (
      .clk     (clk),
      .rst_n   (rst_n),
      .soft_en (soft_en),
      .ack     (cmd_sent),
      .vbit    (vbit)
   );

   generate
      if (EXT_CLK_EN) begin : g_extclk
         vcom_extclk_div #(.EXT_HALF_CYCLES(EXT_HALF_CYCLES)) u_div (
            .clk     (clk),
            .rst_n   (rst_n),
            .run     (pol_src == POL_EXT),
            .clk_out (ext_clk)
         );
      end else begin : g_no_extclk
         assign ext_clk = 1'b0;
      end
   endgenerate
endmodule

// File: rtl/vcom_sched_chk.sv
module vcom_sched_chk #(
   parameter int TOGGLE_CYCLES = 25_000_000
) (
   input logic clk,
   input logic rst_n,
   input logic ext_mode,
   input logic cmd_sent,
   input logic vbit,
   input logic ext_clk,
   input logic toggle_req
);
   localparam int IW = $clog2(TOGGLE_CYCLES + 1);
   localparam logic [IW-1:0] IDLE_FULL = IW'(TOGGLE_CYCLES);

   logic [IW-1:0] idle_cnt;

   always_ff @(posedge clk) begin
      if (!rst_n || ext_mode || cmd_sent) idle_cnt <= '0;
      else if (idle_cnt != IDLE_FULL)     idle_cnt <= idle_cnt + 1'b1;
   end

   // R2
   vbit_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!ext_mode && cmd_sent) |=> (vbit != $past(vbit)));
   // R2
   vbit_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ext_mode || !cmd_sent) |=> $stable(vbit));
   // R3
   req_timing_chk: assert property (@(posedge clk) disable iff (!rst_n)
      toggle_req == (idle_cnt == IDLE_FULL));
   // R4
   req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (toggle_req && !cmd_sent && !ext_mode) |=> toggle_req);
   // R4
   req_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_sent |=> !toggle_req);
   // R8
   ext_noreq_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ext_mode |=> !toggle_req);
   // R7
   extclk_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !ext_mode |=> !ext_clk);
endmodule

bind vcom_sched vcom_sched_chk #(.TOGGLE_CYCLES(TOGGLE_CYCLES)) u_sched_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .ext_mode   (ext_mode),
   .cmd_sent   (cmd_sent),
   .vbit       (vbit),
   .ext_clk    (ext_clk),
   .toggle_req (toggle_req)
);

// File: tb/tb_vcom_sched.sv
module tb_vcom_sched;
   localparam int CLK_PERIOD = 10;
   localparam int T_CYC      = 40;
   localparam int H_CYC      = 5;

   logic clk = 1'b0;
   logic rst_n, ext_mode, cmd_sent;
   logic vbit, ext_clk, toggle_req;

   int n_cmp = 0;
   int n_bad = 0;
   bit ended = 1'b0;

   // reference state, built from the requirements
   int m_idle, m_div;
   bit m_vb, m_req, m_ec;

   always #(CLK_PERIOD/2) clk = ~clk;

   vcom_sched #(
      .CYCLES_PER_SEC  (100),
      .TOGGLE_CYCLES   (T_CYC),
      .EXT_HALF_CYCLES (H_CYC)
   ) dut (
      .clk        (clk),
      .rst_n      (rst_n),
      .ext_mode   (ext_mode),
      .cmd_sent   (cmd_sent),
      .vbit       (vbit),
      .ext_clk    (ext_clk),
      .toggle_req (toggle_req)
   );

   task automatic chk(input string tag, input string nm, input logic act, input logic exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s actual=%0b expected=%0b at %0t", tag, nm, act, exp, $time);
      end
   endtask

   function automatic void model_reset();
      m_idle = 0; m_div = 0; m_vb = 1'b0; m_req = 1'b0; m_ec = 1'b0;
   endfunction

   function automatic void model_step(input bit m, input bit a);
      if (!m) begin
         m_ec = 1'b0; m_div = 0;
         if (a) begin
            m_vb = ~m_vb; m_idle = 0; m_req = 1'b0;
         end else begin
            if (m_idle < T_CYC) m_idle++;
            if (m_idle == T_CYC) m_req = 1'b1;
         end
      end else begin
         m_idle = 0; m_req = 1'b0;
         m_div++;
         if (m_div == H_CYC) begin
            m_div = 0; m_ec = ~m_ec;
         end
      end
   endfunction

   task automatic cyc(input bit m, input bit a, input string tag);
      ext_mode = m;
      cmd_sent = a;
      @(posedge clk);
      model_step(m, a);
      @(negedge clk);
      chk(tag, "vbit", vbit, m_vb);
      chk(tag, "toggle_req", toggle_req, m_req);
      chk(tag, "ext_clk", ext_clk, m_ec);
   endtask

   task automatic summary();
      if (!ended) begin
         ended = 1'b1;
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   endtask

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog expired");
      summary();
   end

   initial begin : main
      bit m_cur;
      void'($urandom(32'd20240611));
      rst_n = 1'b0; ext_mode = 1'b0; cmd_sent = 1'b0;
      model_reset();
      repeat (3) @(posedge clk);
      @(negedge clk);
      // R1: outputs while reset is held
      chk("R1", "vbit", vbit, 1'b0);
      chk("R1", "toggle_req", toggle_req, 1'b0);
      chk("R1", "ext_clk", ext_clk, 1'b0);
      rst_n = 1'b1;

      // R3: timeout counted from reset release
      for (int i = 0; i < T_CYC - 1; i++) cyc(0, 0, "R3");
      chk("R3", "toggle_req early", toggle_req, 1'b0);
      cyc(0, 0, "R3");
      chk("R3", "toggle_req at deadline", toggle_req, 1'b1);

      // R4: request held while the transmitter stays busy, cleared by ack
      for (int i = 0; i < 12; i++) cyc(0, 0, "R4");
      chk("R4", "toggle_req held", toggle_req, 1'b1);
      cyc(0, 1, "R4");
      chk("R4", "toggle_req cleared", toggle_req, 1'b0);
      chk("R2", "vbit after ack", vbit, 1'b1);

      // R5: regular traffic inside the window keeps the request quiet
      for (int r = 0; r < 6; r++) begin
         for (int i = 0; i < T_CYC - 2; i++) cyc(0, 0, "R5");
         cyc(0, 1, "R5");
      end
      chk("R5", "toggle_req", toggle_req, 1'b0);

      // R6: external clock generation
      for (int i = 0; i < H_CYC - 1; i++) cyc(1, 0, "R6");
      chk("R6", "ext_clk before first rise", ext_clk, 1'b0);
      cyc(1, 0, "R6");
      chk("R6", "ext_clk first rise", ext_clk, 1'b1);
      for (int i = 0; i < 4 * H_CYC; i++) cyc(1, 0, "R6");

      // R8: acks are ignored in external mode
      for (int i = 0; i < 3 * T_CYC; i++) cyc(1, (i % 3) == 0, "R8");
      chk("R8", "toggle_req", toggle_req, 1'b0);

      // R7: leaving external mode forces the pin low at once
      cyc(0, 0, "R7");
      chk("R7", "ext_clk", ext_clk, 1'b0);

      // R9: keep-alive restarts from zero after external mode
      for (int i = 0; i < T_CYC - 2; i++) cyc(0, 0, "R9");
      chk("R9", "toggle_req early", toggle_req, 1'b0);
      cyc(0, 0, "R9");
      chk("R9", "toggle_req at deadline", toggle_req, 1'b1);
      cyc(0, 1, "R9");

      // R2: mixed random traffic and mode changes
      m_cur = 1'b0;
      for (int i = 0; i < 4000; i++) begin
         if (($urandom % 300) == 0) m_cur = ~m_cur;
         cyc(m_cur, ($urandom % 55) == 0, "R2");
      end

      summary();
   end
endmodule